// File: doc/BRIEF.md
# Eye-Scan Error Map Sweeper

This block measures how open a receiver's data eye is by moving the sampling point across a two-dimensional grid. One axis is the sampling phase within one unit interval. The other axis is the decision threshold. At every grid point the block compares the sampled bits with a locally regenerated PRBS7 sequence and counts the mismatches. It then stores the mismatch count, together with the number of bits compared, in an on-chip map. An external sampler receives the phase and threshold indices from the block. It returns one decided bit per clock, plus a qualifier. A sampled one means the line was above the selected threshold, and a zero means it was below.

Software or a health monitor loads a settle time and a dwell length, then pulses start. It waits for the done pulse and reads the map back entry by entry. The error count divided by the stored dwell gives the bit error rate at that point. The region of low counts shows the eye opening, and a shrinking region points to a degrading channel.

Top module: `eye_sweep_ctrl`

## Requirements
- R1: During and just after reset, busy_o and done_o are low and both offset outputs are zero.
- R2: A start pulse while idle raises busy_o on the next cycle and selects time index 0, voltage index 0 as the first point.
- R3: Points are visited in this order: time index 0..T_STEPS-1 as the inner loop, voltage index 0..V_STEPS-1 as the outer loop. Each point is visited exactly once per sweep.
- R4: After the offsets move to a new point, exactly settle-count clock cycles pass before any sampled bit is used. Bits in that window have no effect on the map.
- R5: At each point, the first 7 qualified bits after the settle window load the PRBS7 reference (b[n] = b[n-7] XOR b[n-6]) and are not counted.
- R6: The next dwell-count qualified bits are each compared with the reference, and each mismatch adds one to the count. Unqualified cycles, and bits after the dwell is complete, are ignored. A dwell of zero stores a count of zero.
- R7: The error count saturates at 2^ERR_W-1 (16 bits by default) and does not wrap.
- R8: The entry for point (t, v) sits at address v*T_STEPS+t and holds {error count, dwell count}. The read port returns it on rd_err_o/rd_dwell_o one cycle after rd_t_i/rd_v_i are applied.
- R9: The settle and dwell inputs are captured at start. Changing them during a sweep has no effect on that sweep.
- R10: A start pulse while busy is ignored. The sweep neither restarts nor skips.
- R11: done_o is high for exactly one cycle after the last entry is written. busy_o is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sweep (ignored while busy) |
| settle_cfg_i | input | SETTLE_W | Cycles to wait after each offset change |
| dwell_cfg_i | input | DWELL_W | Bits compared per point |
| smp_bit_i | input | 1 | Decided bit from the sampler |
| smp_vld_i | input | 1 | Qualifier for smp_bit_i |
| off_t_o | output | $clog2(T_STEPS) | Selected sampling-phase index |
| off_v_o | output | $clog2(V_STEPS) | Selected threshold index |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse at sweep end |
| rd_t_i | input | $clog2(T_STEPS) | Map read phase index |
| rd_v_i | input | $clog2(V_STEPS) | Map read threshold index |
| rd_err_o | output | ERR_W | Stored error count |
| rd_dwell_o | output | DWELL_W | Stored dwell count |

## Verification
A fault in the index stepping shows on the offset outputs at once, in the cycle of the wrong move, so the offset sequence is compared point by point as it happens. A reference that is seeded late, a settle window counted wrongly, or a dwell window off by one stays hidden until the map is read back. In the bench the settle bits, the bits after the dwell, and the unqualified bits are all corrupted on purpose, so any misalignment changes the stored counts. Each point also gets a distinct number of injected errors, some of them past the saturation limit, so an entry written to the wrong address or a counter that wraps produces a visible count mismatch.

// File: rtl/eye_sweep_pkg.sv
package eye_sweep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_SEED,
      ST_COUNT,
      ST_WRITE
   } sweep_st_e;

   // register length of the reference sequence; also the number of seed bits
   localparam int unsigned PRBS_LEN = 7;
endpackage

// File: rtl/eye_prbs7_ref.sv
// Local PRBS7 reference (b[n] = b[n-7] ^ b[n-6]); loaded from received bits,
// then free-running on its own prediction.
module eye_prbs7_ref (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic adv_i,
   input  logic bit_i,
   output logic exp_o
);
   import eye_sweep_pkg::*;

   logic [PRBS_LEN-1:0] lfsr_q;

   assign exp_o = lfsr_q[PRBS_LEN-1] ^ lfsr_q[PRBS_LEN-2];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lfsr_q <= '0;
      end else if (load_i) begin
         lfsr_q <= {lfsr_q[PRBS_LEN-2:0], bit_i};
      end else if (adv_i) begin
         lfsr_q <= {lfsr_q[PRBS_LEN-2:0], exp_o};
      end
   end

   // R5: a load and an advance never coincide
   assert_no_load_adv_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> !adv_i) else $error("reference loaded and advanced together");
endmodule

// File: rtl/eye_err_counter.sv
// Counts compared bits and mismatches for one grid point.
module eye_err_counter #(
   parameter int unsigned ERR_W  = 16,
   parameter int unsigned SEEN_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              cmp_i,
   input  logic              mis_i,
   output logic [ERR_W-1:0]  err_o,
   output logic [SEEN_W-1:0] seen_o
);
   localparam logic [ERR_W-1:0] ERR_MAX = '1;

   logic [ERR_W-1:0]  err_q;
   logic [SEEN_W-1:0] seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     seen_q <= '0;
      else if (clr_i)  seen_q <= '0;
      else if (cmp_i)  seen_q <= seen_q + 1'b1;
   end

   generate
      if (ERR_W >= SEEN_W) begin : g_plain
         // the count can never exceed the compare length, so no clamp is needed
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                err_q <= '0;
            else if (clr_i)             err_q <= '0;
            else if (cmp_i && mis_i)    err_q <= err_q + 1'b1;
         end
      end else begin : g_sat
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                                err_q <= '0;
            else if (clr_i)                             err_q <= '0;
            else if (cmp_i && mis_i && err_q != ERR_MAX) err_q <= err_q + 1'b1;
         end

         assert_err_sat_hold_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (err_q == ERR_MAX && !clr_i) |=> err_q == ERR_MAX)
            else $error("error count wrapped past its ceiling");
      end
   endgenerate

   assign err_o  = err_q;
   assign seen_o = seen_q;

   assert_err_hold_idle_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !cmp_i) |=> $stable(err_q) && $stable(seen_q))
      else $error("count moved without a compare");
endmodule

// File: rtl/eye_grid_index.sv
// Phase-inner / threshold-outer grid walker.
module eye_grid_index #(
   parameter int unsigned T_STEPS = 32,
   parameter int unsigned V_STEPS = 127,
   parameter int unsigned TW      = 5,
   parameter int unsigned VW      = 7
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          step_i,
   output logic [TW-1:0] t_o,
   output logic [VW-1:0] v_o,
   output logic          last_o
);
   localparam logic [TW-1:0] TMAX = TW'(T_STEPS - 1);
   localparam logic [VW-1:0] VMAX = VW'(V_STEPS - 1);

   logic [TW-1:0] t_q;
   logic [VW-1:0] v_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         t_q <= '0;
         v_q <= '0;
      end else if (clr_i) begin
         t_q <= '0;
         v_q <= '0;
      end else if (step_i) begin
         if (t_q == TMAX) begin
            t_q <= '0;
            v_q <= v_q + 1'b1;
         end else begin
            t_q <= t_q + 1'b1;
         end
      end
   end

   assign t_o    = t_q;
   assign v_o    = v_q;
   assign last_o = (t_q == TMAX) && (v_q == VMAX);

   assert_time_inner_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !clr_i && t_q != TMAX) |=> (t_q == $past(t_q) + 1'b1) && $stable(v_q))
      else $error("phase index did not advance by one");

   assert_volt_outer_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !clr_i && t_q == TMAX) |=> (t_q == '0) && (v_q == $past(v_q) + 1'b1))
      else $error("threshold index did not advance on phase wrap");
endmodule

// File: rtl/eye_map_ram.sv
// Result store, one write port and one registered read port.
module eye_map_ram #(
   parameter int unsigned DEPTH = 4064,
   parameter int unsigned AW    = 12,
   parameter int unsigned DW    = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   logic [DW-1:0] mem_q [DEPTH];
   logic [DW-1:0] rdata_q;

   always_ff @(posedge clk_i) begin
      if (we_i && int'(waddr_i) < DEPTH) mem_q[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    rdata_q <= '0;
      else if (int'(raddr_i) < DEPTH) rdata_q <= mem_q[raddr_i];
      else                            rdata_q <= '0;
   end

   assign rdata_o = rdata_q;

   assert_write_in_range_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |-> int'(waddr_i) < DEPTH) else $error("map write outside the grid");
endmodule

// File: rtl/eye_sweep_ctrl.sv
// Two-dimensional eye sweep controller: walks the offset grid, settles,
// seeds a PRBS7 reference, counts mismatches and records a map entry per point.
module eye_sweep_ctrl #(
   parameter int unsigned T_STEPS  = 32,
   parameter int unsigned V_STEPS  = 127,
   parameter int unsigned ERR_W    = 16,
   parameter int unsigned DWELL_W  = 16,
   parameter int unsigned SETTLE_W = 8,
   localparam int unsigned TW      = $clog2(T_STEPS),
   localparam int unsigned VW      = $clog2(V_STEPS)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_i,
   input  logic [SETTLE_W-1:0] settle_cfg_i,
   input  logic [DWELL_W-1:0]  dwell_cfg_i,
   input  logic                smp_bit_i,
   input  logic                smp_vld_i,
   output logic [TW-1:0]       off_t_o,
   output logic [VW-1:0]       off_v_o,
   output logic                busy_o,
   output logic                done_o,
   input  logic [TW-1:0]       rd_t_i,
   input  logic [VW-1:0]       rd_v_i,
   output logic [ERR_W-1:0]    rd_err_o,
   output logic [DWELL_W-1:0]  rd_dwell_o
);
   import eye_sweep_pkg::*;

   localparam int unsigned DEPTH = T_STEPS * V_STEPS;
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned DW    = ERR_W + DWELL_W;
   localparam int unsigned SDW   = $clog2(PRBS_LEN);
   localparam logic [SDW-1:0] SEED_LAST = SDW'(PRBS_LEN - 1);

   generate
      if (T_STEPS < 2)  begin : g_bad_t  $error("T_STEPS must be at least 2");  end
      if (V_STEPS < 2)  begin : g_bad_v  $error("V_STEPS must be at least 2");  end
      if (ERR_W < 1)    begin : g_bad_e  $error("ERR_W must be positive");      end
      if (DWELL_W < 1)  begin : g_bad_d  $error("DWELL_W must be positive");    end
      if (SETTLE_W < 1) begin : g_bad_s  $error("SETTLE_W must be positive");   end
   endgenerate

   sweep_st_e           st_q;
   logic [SETTLE_W-1:0] settle_lat_q, settle_cnt_q;
   logic [DWELL_W-1:0]  dwell_lat_q;
   logic [SDW-1:0]      seed_cnt_q;
   logic                done_q;

   logic          idx_clr, idx_step, idx_last;
   logic [TW-1:0] t_idx;
   logic [VW-1:0] v_idx;
   logic          seed_load, cmp_en, cnt_clr, mem_we;
   logic          ref_exp;
   logic [ERR_W-1:0]   err_cnt;
   logic [DWELL_W-1:0] seen_cnt;
   logic [AW-1:0] waddr, raddr;
   logic [DW-1:0] rdata;

   // ---------------- control decode ----------------
   always_comb begin
      idx_clr   = 1'b0;
      idx_step  = 1'b0;
      seed_load = 1'b0;
      cmp_en    = 1'b0;
      cnt_clr   = 1'b0;
      mem_we    = 1'b0;
      unique case (st_q)
         ST_IDLE:   idx_clr   = start_i;
         ST_SETTLE: cnt_clr   = 1'b1;
         ST_SEED:   seed_load = smp_vld_i;
         ST_COUNT:  cmp_en    = smp_vld_i && (seen_cnt != dwell_lat_q);
         ST_WRITE: begin
            mem_we   = 1'b1;
            idx_step = !idx_last;
         end
         default: ;
      endcase
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q         <= ST_IDLE;
         settle_lat_q <= '0;
         settle_cnt_q <= '0;
         dwell_lat_q  <= '0;
         seed_cnt_q   <= '0;
         done_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  settle_lat_q <= settle_cfg_i;
                  dwell_lat_q  <= dwell_cfg_i;
                  settle_cnt_q <= '0;
                  st_q         <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_cnt_q == settle_lat_q) begin
                  seed_cnt_q <= '0;
                  st_q       <= ST_SEED;
               end else begin
                  settle_cnt_q <= settle_cnt_q + 1'b1;
               end
            end
            ST_SEED: begin
               if (smp_vld_i) begin
                  if (seed_cnt_q == SEED_LAST) st_q <= ST_COUNT;
                  else                         seed_cnt_q <= seed_cnt_q + 1'b1;
               end
            end
            ST_COUNT: begin
               if (seen_cnt == dwell_lat_q) st_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (idx_last) begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  settle_cnt_q <= '0;
                  st_q         <= ST_SETTLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- datapath ----------------
   eye_grid_index #(
      .T_STEPS(T_STEPS), .V_STEPS(V_STEPS), .TW(TW), .VW(VW)
   ) grid_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (idx_clr),
      .step_i (idx_step),
      .t_o    (t_idx),
      .v_o    (v_idx),
      .last_o (idx_last)
   );

   eye_prbs7_ref ref_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (seed_load),
      .adv_i  (cmp_en),
      .bit_i  (smp_bit_i),
      .exp_o  (ref_exp)
   );

   eye_err_counter #(.ERR_W(ERR_W), .SEEN_W(DWELL_W)) cnt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr),
      .cmp_i  (cmp_en),
      .mis_i  (smp_bit_i ^ ref_exp),
      .err_o  (err_cnt),
      .seen_o (seen_cnt)
   );

   assign waddr = AW'(v_idx) * AW'(T_STEPS) + AW'(t_idx);
   assign raddr = AW'(rd_v_i) * AW'(T_STEPS) + AW'(rd_t_i);

   eye_map_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) map_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (mem_we),
      .waddr_i (waddr),
      .wdata_i ({err_cnt, dwell_lat_q}),
      .raddr_i (raddr),
      .rdata_o (rdata)
   );

   assign off_t_o    = t_idx;
   assign off_v_o    = v_idx;
   assign busy_o     = (st_q != ST_IDLE);
   assign done_o     = done_q;
   assign rd_err_o   = rdata[DW-1 -: ERR_W];
   assign rd_dwell_o = rdata[DWELL_W-1:0];

   // ---------------- checks ----------------
   assert_settle_after_move_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !$stable({t_idx, v_idx})) |-> st_q == ST_SETTLE)
      else $error("offsets moved outside a settle window");

   assert_dwell_bound_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_COUNT) |-> seen_cnt <= dwell_lat_q)
      else $error("compared more bits than the dwell");

   assert_cfg_held_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> $stable(dwell_lat_q) && $stable(settle_lat_q))
      else $error("captured configuration changed mid-sweep");

   assert_start_ignored_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i && st_q != ST_WRITE) |=> busy_o && $stable({t_idx, v_idx}))
      else $error("start while busy disturbed the sweep");

   assert_done_pulse_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o) else $error("done held longer than one cycle");

   assert_done_idle_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o) else $error("done raised while still busy");
endmodule

// File: tb/eye_sweep_ctrl_tb_top.sv
module eye_sweep_ctrl_tb_top;
   localparam int T    = 4;
   localparam int V    = 3;
   localparam int EW   = 4;
   localparam int DWW  = 8;
   localparam int SW   = 4;
   localparam int TW   = 2;
   localparam int VW   = 2;
   localparam int EMAX = (1 << EW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic           start = 1'b0;
   logic [SW-1:0]  settle_cfg = '0;
   logic [DWW-1:0] dwell_cfg = '0;
   logic           smp_bit = 1'b0, smp_vld = 1'b0;
   logic [TW-1:0]  off_t, rd_t = '0;
   logic [VW-1:0]  off_v, rd_v = '0;
   logic           busy, done;
   logic [EW-1:0]  rd_err;
   logic [DWW-1:0] rd_dwell;

   eye_sweep_ctrl #(
      .T_STEPS(T), .V_STEPS(V), .ERR_W(EW), .DWELL_W(DWW), .SETTLE_W(SW)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .settle_cfg_i(settle_cfg), .dwell_cfg_i(dwell_cfg),
      .smp_bit_i(smp_bit), .smp_vld_i(smp_vld),
      .off_t_o(off_t), .off_v_o(off_v), .busy_o(busy), .done_o(done),
      .rd_t_i(rd_t), .rd_v_i(rd_v), .rd_err_o(rd_err), .rd_dwell_o(rd_dwell)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // stimulus model state
   int S_exp = 0, D_exp = 0, run_id = 0;
   int m = 0, k = 0, ev_idx = 0, cyc = 0, done_cnt = 0;
   int cur_t = 0, cur_v = 0, prev_t = 0, prev_v = 0;
   bit prev_busy = 1'b0, done_prev = 1'b0;
   logic [6:0] ps = 7'h5A;

   function automatic int nerr(input int t, input int v);
      return (t * 7 + v * 5 + run_id * 3) % (D_exp + 1);
   endfunction

   // sampler model: clean PRBS7 inside the seed/compare window, planted
   // errors per point, corrupted bits everywhere the design must ignore
   always @(negedge clk) begin
      bit vld, b, nb, inj;
      int j;
      cyc++;
      if (rst_n) begin
         if (busy && (!prev_busy || int'(off_t) != prev_t || int'(off_v) != prev_v)) begin
            if (!prev_busy) begin
               ev_idx = 0;
               chk(off_t == 0 && off_v == 0, "R2 first point", int'(off_v) * T + int'(off_t), 0);
            end
            chk(int'(off_t) == ev_idx % T && int'(off_v) == ev_idx / T, "R3 sweep order",
                int'(off_v) * T + int'(off_t), ev_idx);
            cur_t = off_t; cur_v = off_v;
            m = 0; k = 0;
            ev_idx++;
         end else begin
            m++;
         end
         if (done_prev) chk(!done, "R11 done width", done, 0);
         if (done) begin
            done_cnt++;
            chk(!busy, "R11 busy low at done", busy, 0);
            chk(ev_idx == T * V, "R3 points visited", ev_idx, T * V);
         end
         prev_busy = busy; prev_t = off_t; prev_v = off_v; done_prev = done;
      end
      vld = (cyc % 7) != 5;
      if (vld) begin
         nb = ps[6] ^ ps[5];
         ps = {ps[5:0], nb};
         b  = nb;
      end else begin
         b = (cyc % 2) == 1;
      end
      if (busy) begin
         if (m < S_exp + 1) begin
            b = ~b;                                  // R4: settle window corrupted
         end else if (vld) begin
            if (k >= 7) begin                        // R5: first 7 left clean
               j = k - 7;
               if (j < D_exp) inj = (j < nerr(cur_t, cur_v));
               else           inj = 1'b1;            // R6: past dwell, corrupted
               b = b ^ inj;
            end
            k++;
         end
      end
      smp_bit = b;
      smp_vld = vld;
   end

   task automatic run_sweep(input int s, input int d, input int rid);
      int e;
      S_exp = s; D_exp = d; run_id = rid;
      settle_cfg = SW'(s); dwell_cfg = DWW'(d);
      done_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R2 busy after start", busy, 1);
      settle_cfg = SW'(s + 5);                     // R9: late changes must not matter
      dwell_cfg  = DWW'(d + 3);
      repeat (30) @(negedge clk);
      chk(busy, "R10 still busy before extra start", busy, 1);
      start = 1'b1;                                // R10: ignored
      @(negedge clk);
      start = 1'b0;
      for (int w = 0; w < 20000 && done_cnt == 0; w++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(done_cnt == 1, "R11 single done pulse", done_cnt, 1);
      for (int v = 0; v < V; v++) begin
         for (int t = 0; t < T; t++) begin
            rd_t = TW'(t); rd_v = VW'(v);
            @(negedge clk);
            e = nerr(t, v);
            if (e > EMAX) chk(int'(rd_err) == EMAX, "R7 saturated count", rd_err, EMAX);
            else          chk(int'(rd_err) == e, "R6 R8 error count", rd_err, e);
            chk(int'(rd_dwell) == d, "R8 R9 stored dwell", rd_dwell, d);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R1 idle in reset", {busy, done}, 0);
      chk(off_t == 0 && off_v == 0, "R1 offsets in reset", int'(off_v) * T + int'(off_t), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && off_t == 0 && off_v == 0, "R1 idle after reset", busy, 0);
      run_sweep(3, 20, 0);
      run_sweep(0, 0, 1);
      run_sweep(1, 9, 2);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule